// File: doc/BRIEF.md
# Total-Store-Order Write Buffer

This block sits between a core's retirement stage and its data cache. It keeps stores that have already retired until the cache can take them. Each retired store enters a first-in first-out queue, together with its word address, its data word, a byte-enable mask and the identifier of the hardware thread that issued it. The oldest entry is offered to the cache on a valid/ready drain port. It leaves the queue only when the cache accepts it and reports that it holds the line with write permission. Store-to-store order is therefore never broken.

Loads look into the buffer in the same cycle they are presented. The buffer searches for the youngest entry with the same thread tag and the same word address. If that entry's byte mask covers every byte the load needs, the load takes the entry's data. If it covers only some of those bytes, the load is told to stall. If no entry matches, the load may go to the cache ahead of the older buffered stores.

A fence request stops new commits and holds every load until the queue has fully drained. A one-cycle done pulse then reopens both paths.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the buffer is empty. `dr_valid` is 0, `commit_ready` is 1, `fence_busy` is 0 and `fence_done` is 0.
- R2: A store is accepted on a clock edge where `commit_valid` and `commit_ready` are both 1. After DEPTH stores are held, `commit_ready` is 0 and `commit_valid` is ignored until an entry leaves.
- R3: While the buffer holds entries, `dr_valid` is 1 and the drain port shows the oldest entry's address, data, mask and thread. Entries leave in the order they were accepted.
- R4: The head entry is removed only on an edge where `dr_ready` and `dr_wperm` are both 1. Otherwise the head stays, with the same fields.
- R5: A valid load whose thread and word address match buffered entries uses the youngest such entry. If that entry's mask covers every bit set in `ld_mask`, `ld_hit` is 1 and `ld_data` equals that entry's full data word.
- R6: Entries tagged with a different thread never match a load, even at the same address.
- R7: A load with no matching entry gives `ld_hit` = 0, `ld_stall` = 0 and `ld_data` = 0. It is not ordered behind the older stores.
- R8: If the youngest match lacks any byte that `ld_mask` requests, `ld_stall` is 1 and `ld_hit` is 0. `ld_hit` and `ld_stall` are never 1 together.
- R9: A `fence_req` pulse while no fence is pending sets `fence_busy` from the next cycle. While `fence_busy` is 1, `commit_ready` is 0 and every valid load sees `ld_stall` = 1 and `ld_hit` = 0.
- R10: `fence_done` is 1 for exactly one cycle, in the first cycle where `fence_busy` is 1 and the buffer is empty. `fence_busy` falls on the next edge. A fence raised on an empty buffer therefore signals done in the following cycle.
- R11: A `fence_req` raised while a fence is already pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | A retired store is offered |
| commit_ready | output | 1 | Buffer can accept a store |
| commit_addr | input | 30 | Word address of the store |
| commit_data | input | 32 | Store data word |
| commit_mask | input | 4 | Byte enables of the store |
| commit_tid | input | 1 | Thread tag of the store |
| ld_valid | input | 1 | A load is looking up the buffer |
| ld_addr | input | 30 | Word address of the load |
| ld_tid | input | 1 | Thread tag of the load |
| ld_mask | input | 4 | Bytes the load needs |
| ld_hit | output | 1 | Load fully served from the buffer |
| ld_stall | output | 1 | Load must wait (partial cover or fence) |
| ld_data | output | 32 | Forwarded data word, zero without a hit |
| dr_valid | output | 1 | Head entry offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered entry |
| dr_wperm | input | 1 | Cache holds the line writable |
| dr_addr | output | 30 | Head entry word address |
| dr_data | output | 32 | Head entry data |
| dr_mask | output | 4 | Head entry byte enables |
| dr_tid | output | 1 | Head entry thread tag |
| fence_req | input | 1 | Fence request pulse |
| fence_busy | output | 1 | Fence pending: commits and loads held |
| fence_done | output | 1 | One-cycle pulse when the fence completes |

## Verification
A corrupted pointer or occupancy count appears on the drain port in the next cycle, as a wrong head entry or a wrong `dr_valid`. It also appears on `commit_ready` as soon as the count approaches DEPTH. A wrong age order or tag comparison in the forwarding search appears at once as wrong `ld_data`, a missing hit or a false stall, in the same cycle the load is presented. A fence state that does not clear shows up as `commit_ready` held low, or as a missing or doubled `fence_done`, one cycle after the buffer empties. The bench models the queue behaviourally and compares every output on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/tsob_pkg.sv
package tsob_pkg;

    localparam int ADDR_W    = 30;
    localparam int DATA_W    = 32;
    localparam int BYTE_N    = DATA_W / 8;
    localparam int THREADS   = 2;
    localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1;
    localparam int DEPTH_DEF = 8;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0] wdata_t;
    typedef logic [BYTE_N-1:0] bmask_t;
    typedef logic [TID_W-1:0]  tid_t;

    typedef struct packed {
        waddr_t addr;
        wdata_t data;
        bmask_t mask;
        tid_t   tid;
    } sb_entry_t;

    typedef enum logic {
        FN_IDLE  = 1'b0,
        FN_DRAIN = 1'b1
    } fence_st_t;

    function automatic logic mask_covers(bmask_t need, bmask_t have);
        return (need & ~have) == '0;
    endfunction

endpackage

// File: rtl/tsob_storage.sv
module tsob_storage
    import tsob_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  sb_entry_t       push_ent,
    input  logic            pop,
    output sb_entry_t       slots [DEPTH],
    output logic [PW-1:0]   head,
    output logic [CW-1:0]   occ
);

    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] occ_q;
    sb_entry_t     mem_q [DEPTH];

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (push) tail_q <= ptr_next(tail_q);
            if (pop)  head_q <= ptr_next(head_q);
            case ({push, pop})
                2'b10:   occ_q <= occ_q + CW'(1);
                2'b01:   occ_q <= occ_q - CW'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[tail_q] <= push_ent;
    end

    assign slots = mem_q;
    assign head  = head_q;
    assign occ   = occ_q;

endmodule

// File: rtl/tsob_fwd.sv
module tsob_fwd
    import tsob_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  sb_entry_t       slots [DEPTH],
    input  logic [PW-1:0]   head,
    input  logic [CW-1:0]   occ,
    input  waddr_t          ld_addr,
    input  tid_t            ld_tid,
    input  bmask_t          ld_mask,
    output logic            match,
    output logic            covered,
    output wdata_t          fwd_data
);

    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] hitv;
    logic [PW-1:0]    sel;

    // Per-slot liveness and tag/address compare.
    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            localparam int SLOT = s;
            logic [CW-1:0] age;
            always_comb begin
                age = (SLOT >= int'(head)) ? CW'(SLOT - int'(head))
                                           : CW'(SLOT + DEPTH - int'(head));
                live[s] = age < occ;
                hitv[s] = live[s] && (slots[s].tid == ld_tid)
                                  && (slots[s].addr == ld_addr);
            end
        end
    endgenerate

    // Walk from oldest to youngest: the last hit is the youngest store.
    always_comb begin
        match = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int slot;
            slot = (int'(head) + k) % DEPTH;
            if (hitv[slot]) begin
                match = 1'b1;
                sel   = PW'(slot);
            end
        end
        covered  = match && mask_covers(ld_mask, slots[sel].mask);
        fwd_data = slots[sel].data;
    end

endmodule

// File: rtl/tsob_fence.sv
module tsob_fence
    import tsob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fence_req,
    input  logic empty,
    output logic busy,
    output logic done
);

    fence_st_t st_q;

    assign busy = (st_q == FN_DRAIN);
    assign done = busy && empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= FN_IDLE;
        end else begin
            case (st_q)
                FN_IDLE:  if (fence_req) st_q <= FN_DRAIN;
                FN_DRAIN: if (empty)     st_q <= FN_IDLE;
                default:                 st_q <= FN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import tsob_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit_valid,
    output logic               commit_ready,
    input  logic [ADDR_W-1:0]  commit_addr,
    input  logic [DATA_W-1:0]  commit_data,
    input  logic [BYTE_N-1:0]  commit_mask,
    input  logic [TID_W-1:0]   commit_tid,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [TID_W-1:0]   ld_tid,
    input  logic [BYTE_N-1:0]  ld_mask,
    output logic               ld_hit,
    output logic               ld_stall,
    output logic [DATA_W-1:0]  ld_data,
    output logic               dr_valid,
    input  logic               dr_ready,
    input  logic               dr_wperm,
    output logic [ADDR_W-1:0]  dr_addr,
    output logic [DATA_W-1:0]  dr_data,
    output logic [BYTE_N-1:0]  dr_mask,
    output logic [TID_W-1:0]   dr_tid,
    input  logic               fence_req,
    output logic               fence_busy,
    output logic               fence_done
);

    sb_entry_t     slots [DEPTH];
    sb_entry_t     in_ent, head_ent;
    logic [PW-1:0] head;
    logic [CW-1:0] occ;
    logic          empty, full, push, pop;
    logic          match, covered;
    wdata_t        fwd_data;

    assign empty = (occ == '0);
    assign full  = (int'(occ) == DEPTH);

    assign in_ent = '{addr: commit_addr, data: commit_data,
                      mask: commit_mask, tid: commit_tid};

    assign commit_ready = !full && !fence_busy;
    assign push         = commit_valid && commit_ready;
    assign pop          = dr_valid && dr_ready && dr_wperm;

    tsob_storage #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (in_ent),
        .pop      (pop),
        .slots    (slots),
        .head     (head),
        .occ      (occ)
    );

    assign head_ent = slots[head];
    assign dr_valid = !empty;
    assign dr_addr  = head_ent.addr;
    assign dr_data  = head_ent.data;
    assign dr_mask  = head_ent.mask;
    assign dr_tid   = head_ent.tid;

    tsob_fwd #(.DEPTH(DEPTH)) u_fwd (
        .slots    (slots),
        .head     (head),
        .occ      (occ),
        .ld_addr  (ld_addr),
        .ld_tid   (ld_tid),
        .ld_mask  (ld_mask),
        .match    (match),
        .covered  (covered),
        .fwd_data (fwd_data)
    );

    tsob_fence u_fence (
        .clk       (clk),
        .rst       (rst),
        .fence_req (fence_req),
        .empty     (empty),
        .busy      (fence_busy),
        .done      (fence_done)
    );

    assign ld_hit   = ld_valid && !fence_busy && match && covered;
    assign ld_stall = ld_valid && (fence_busy || (match && !covered));
    assign ld_data  = ld_hit ? fwd_data : '0;

endmodule

// File: rtl/tsob_chk.sv
module tsob_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int AW    = 30,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] occ,
    input logic          commit_ready,
    input logic          dr_valid,
    input logic          dr_ready,
    input logic          dr_wperm,
    input logic [AW-1:0] dr_addr,
    input logic [DW-1:0] dr_data,
    input logic          ld_hit,
    input logic          ld_stall,
    input logic          fence_busy,
    input logic          fence_done
);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

    // R2
    full_blocks_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(occ) == DEPTH) |-> !commit_ready);

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !(dr_ready && dr_wperm))
            |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

    // R8
    hit_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_hit && ld_stall));

    // R9
    fence_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        fence_busy |-> (!commit_ready && !ld_hit));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fence_done |=> (!fence_done && !fence_busy));

    // R10
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fence_done |-> !dr_valid);

endmodule

bind tso_store_buffer tsob_chk #(
    .DEPTH (DEPTH),
    .CW    (CW),
    .AW    (tsob_pkg::ADDR_W),
    .DW    (tsob_pkg::DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .occ          (occ),
    .commit_ready (commit_ready),
    .dr_valid     (dr_valid),
    .dr_ready     (dr_ready),
    .dr_wperm     (dr_wperm),
    .dr_addr      (dr_addr),
    .dr_data      (dr_data),
    .ld_hit       (ld_hit),
    .ld_stall     (ld_stall),
    .fence_busy   (fence_busy),
    .fence_done   (fence_done)
);

// File: tb/tso_store_buffer_bench.sv
`timescale 1ns/1ps
module tso_store_buffer_bench;

    localparam int DEPTH = 8;

    typedef struct {
        logic [29:0] a;
        logic [31:0] d;
        logic [3:0]  m;
        logic        t;
    } ref_ent_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        cv, lv, drr, dwp, fr;
    logic [29:0] ca, la;
    logic [31:0] cd;
    logic [3:0]  cm, lm;
    logic        ct, lt;

    logic        commit_ready, ld_hit, ld_stall, dr_valid;
    logic        fence_busy, fence_done;
    logic [31:0] ld_data, dr_data;
    logic [29:0] dr_addr;
    logic [3:0]  dr_mask;
    logic        dr_tid;

    ref_ent_t q[$];
    bit       fbusy;
    int       checks = 0;
    int       fails  = 0;
    bit       finished = 0;

    always #2.5 clk = ~clk;

    tso_store_buffer u_tso_store_buffer (
        .clk(clk), .rst(rst),
        .commit_valid(cv), .commit_ready(commit_ready),
        .commit_addr(ca), .commit_data(cd), .commit_mask(cm), .commit_tid(ct),
        .ld_valid(lv), .ld_addr(la), .ld_tid(lt), .ld_mask(lm),
        .ld_hit(ld_hit), .ld_stall(ld_stall), .ld_data(ld_data),
        .dr_valid(dr_valid), .dr_ready(drr), .dr_wperm(dwp),
        .dr_addr(dr_addr), .dr_data(dr_data), .dr_mask(dr_mask), .dr_tid(dr_tid),
        .fence_req(fr), .fence_busy(fence_busy), .fence_done(fence_done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs against the queue model, then advance one clock.
    task automatic step(input string tag);
        bit er, edv, eh, es, ed, found;
        logic [31:0] efd;
        #1;
        er  = (q.size() < DEPTH) && !fbusy;
        edv = q.size() > 0;
        ed  = fbusy && (q.size() == 0);
        found = 0; eh = 0; es = 0; efd = '0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (!found && q[i].t == lt && q[i].a == la) begin
                found = 1;
                if ((lm & ~q[i].m) != 4'h0) es = 1;
                else begin eh = 1; efd = q[i].d; end
            end
        end
        if (fbusy) begin eh = 0; es = 1; efd = '0; end
        if (!lv)   begin eh = 0; es = 0; efd = '0; end
        chk(commit_ready === er, tag, "commit_ready", 64'(commit_ready), 64'(er));
        chk(dr_valid === edv, tag, "dr_valid", 64'(dr_valid), 64'(edv));
        if (edv) begin
            chk({dr_addr, dr_data, dr_mask, dr_tid} === {q[0].a, q[0].d, q[0].m, q[0].t},
                tag, "drain head", {dr_addr, dr_tid}, {q[0].a, q[0].t});
        end
        chk(ld_hit === eh, tag, "ld_hit", 64'(ld_hit), 64'(eh));
        chk(ld_stall === es, tag, "ld_stall", 64'(ld_stall), 64'(es));
        chk(ld_data === efd, tag, "ld_data", 64'(ld_data), 64'(efd));
        chk(fence_busy === fbusy, tag, "fence_busy", 64'(fence_busy), 64'(fbusy));
        chk(fence_done === ed, tag, "fence_done", 64'(fence_done), 64'(ed));
        @(posedge clk);
        if (edv && drr && dwp) void'(q.pop_front());
        if (cv && er) q.push_back('{a: ca, d: cd, m: cm, t: ct});
        if (ed) fbusy = 0;
        else if (fr && !fbusy) fbusy = 1;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cv = 0; lv = 0; drr = 0; dwp = 0; fr = 0;
        ca = '0; cd = '0; cm = '0; ct = 0; la = '0; lt = 0; lm = '0;
    endtask

    task automatic commit(input logic [29:0] a, input logic [31:0] d,
                          input logic [3:0] m, input logic t, input string tag);
        cv = 1; ca = a; cd = d; cm = m; ct = t;
        step(tag);
        cv = 0;
    endtask

    task automatic load(input logic [29:0] a, input logic t,
                        input logic [3:0] m, input string tag);
        lv = 1; la = a; lt = t; lm = m;
        step(tag);
        lv = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        fbusy = 0;
        step("R1");

        // Forwarding and thread isolation, drain held off.
        commit(30'h100, 32'h1111_1111, 4'hF, 1'b0, "R2");
        commit(30'h100, 32'h2222_2222, 4'h3, 1'b0, "R2");
        commit(30'h100, 32'h3333_3333, 4'hF, 1'b1, "R2");
        load(30'h100, 1'b0, 4'h3, "R5");    // youngest t0 covers low bytes
        load(30'h100, 1'b0, 4'hF, "R8");    // youngest t0 lacks upper bytes
        load(30'h100, 1'b1, 4'hF, "R6");    // only t1 entry used
        load(30'h200, 1'b0, 4'hF, "R7");    // no match
        commit(30'h100, 32'h4444_4444, 4'hF, 1'b0, "R5");
        load(30'h100, 1'b0, 4'hF, "R5");    // now full cover from newest

        // Fill to full, extra commit refused.
        for (int i = 0; i < 4; i++)
            commit(30'h300 + 30'(i), 32'hA000_0000 + 32'(i), 4'hF, 1'b1, "R2");
        commit(30'h3FF, 32'hDEAD_BEEF, 4'hF, 1'b0, "R2");
        commit(30'h3FE, 32'hDEAD_0000, 4'hF, 1'b0, "R2");
        load(30'h3FE, 1'b0, 4'hF, "R2");

        // Drain offered without write permission: head holds.
        drr = 1; dwp = 0;
        repeat (3) step("R4");
        drr = 0; dwp = 1;
        repeat (2) step("R4");
        drr = 1; dwp = 1;
        repeat (3) step("R3");
        drr = 0; dwp = 0;

        // Fence with entries left: commits and loads held until empty.
        fr = 1; step("R9"); fr = 0;
        commit(30'h500, 32'h5555_5555, 4'hF, 1'b0, "R9");
        load(30'h300, 1'b1, 4'hF, "R9");
        fr = 1; step("R11"); fr = 0;
        drr = 1; dwp = 1;
        repeat (7) step("R10");
        drr = 0; dwp = 0;
        repeat (2) step("R10");

        // Fence on an empty buffer completes the cycle after.
        fr = 1; step("R10"); fr = 0;
        step("R10");
        step("R10");

        // Mixed traffic over a small address space.
        for (int n = 0; n < 600; n++) begin
            cv  = ($urandom % 3) != 0;
            ca  = 30'($urandom % 4); cd = $urandom; cm = 4'($urandom % 16 + 1);
            ct  = 1'($urandom % 2);
            lv  = ($urandom % 2) != 0;
            la  = 30'($urandom % 4); lt = 1'($urandom % 2); lm = 4'($urandom % 16);
            drr = ($urandom % 2) != 0; dwp = ($urandom % 4) != 0;
            fr  = ($urandom % 25) == 0;
            step("R3");
        end
        idle_inputs();
        drr = 1; dwp = 1;
        repeat (12) step("R3");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule